// File: doc/BRIEF.md
# Watchdog Timer with Pre-Timeout Interrupt and External Reset Output

This block is a watchdog timer behind a small synchronous 16-bit register port. Its countdown advances only on cycles where the slow-clock enable `tick_i` is high, which in the chip marks one period of a 32.768 kHz clock. Software arms the timer with a timeout given in half-second units. It must keep the timer alive by writing a two-word key pair to the service register. If the count runs out, the block either pulses an internal system reset request or drives an active-low external reset pin, depending on a control bit.

An optional interrupt can fire a programmable number of half-second units before expiry. Software can also request a system reset or the external reset pin directly. Both of these requests are active-low control bits that act on the next slow tick. A status register records why the most recent reset happened. A separate power-down watchdog enable is brought out as a pin, and software can clear it but cannot set it.

An internal reset reinitialises every register except the status register, which then holds the cause, and the power-down enable.

Top module: `wdog_top`

## Requirements
- R1: After `rst_ni` is released, control (offset 0x0) reads 0x0030, status (offset 0x4) reads 0x0010, miscellaneous (offset 0x8) reads 0x0001, `ext_rst_no` is 1, and `irq_o` and `sys_rst_o` are 0.
- R2: When control bit 2 (enable) is set and control bit 3 is 0, `sys_rst_o` pulses for one cycle after (WT+1)*HALF_TICKS slow ticks, where WT is control bits 15:8. Afterwards status reads 0x0002 (bit 1 = timeout) and control reads 0x0030 again.
- R3: Writing 0x5555 and then 0xAAAA to the service register (offset 0x2) restarts the full timeout. A write of 0xAAAA without a directly preceding 0x5555 does not restart it, and neither does a pair broken by any other value.
- R4: Once set, control bit 2 cannot be cleared by a register write. Only a reset clears it.
- R5: While control bit 1 is set and `dbg_i` is high, the countdown holds. The same applies to bit 0 with `lp_i` and to bit 7 with `wait_i`.
- R6: Interrupt control (offset 0x6) bit 14 is set when the remaining time reaches bits 7:0 half-second units. `irq_o` equals bit 14 AND bit 15. Writing 1 to bit 14 clears it.
- R7: With control bit 3 set, expiry drives `ext_rst_no` low and keeps it low until reset. No `sys_rst_o` pulse occurs and the status register is unchanged.
- R8: Clearing control bit 5 drives `ext_rst_no` low at the next slow tick, not before. Setting the bit again releases the pin at the following tick.
- R9: Clearing control bit 4 causes a one-cycle `sys_rst_o` pulse at the next slow tick, not before. Afterwards status reads 0x0001.
- R10: `pd_wdog_en_o` mirrors miscellaneous bit 0. Writing 0 to that bit clears it. Writing 1 has no effect.
- R11: A new timeout value written into control bits 15:8 while the timer runs does not change the current countdown. It applies from the next service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Slow-clock enable, one cycle per slow period |
| dbg_i | input | 1 | Chip in debug state |
| lp_i | input | 1 | Chip in low-power state |
| wait_i | input | 1 | Chip in wait state |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | AW | Byte address of the 16-bit register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| irq_o | output | 1 | Pre-timeout interrupt |
| ext_rst_no | output | 1 | External reset pin, active low |
| sys_rst_o | output | 1 | One-cycle internal system reset request |
| pd_wdog_en_o | output | 1 | Power-down watchdog enable |

## Verification
The bench counts slow ticks exactly. It checks that expiry lands on tick (WT+1)*HALF_TICKS and not one tick early, which exposes an off-by-one counter that would reset too soon or too late. It sends broken key sequences (a lone 0xAAAA, or 0x5555 followed by a stray value) that a lax sequence tracker would accept, extending the timeout when it should not. It also checks that the active-low requests wait for a slow tick rather than acting on the write cycle, and that the interrupt flag clears only by writing one. Finally, it rewrites the timeout while the timer runs: a design that reloads on that write would move the expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_SVC  = 4'h2;
  localparam logic [3:0] OFF_STAT = 4'h4;
  localparam logic [3:0] OFF_ICTL = 4'h6;
  localparam logic [3:0] OFF_MISC = 4'h8;

  localparam int CB_LPS   = 0;
  localparam int CB_DBGS  = 1;
  localparam int CB_EN    = 2;
  localparam int CB_EXTTO = 3;
  localparam int CB_SWRN  = 4;
  localparam int CB_EXTRN = 5;
  localparam int CB_WAITS = 7;
  localparam int IB_FLAG  = 14;
  localparam int IB_IE    = 15;

  localparam logic [15:0] SVC_KEY_A = 16'h5555;
  localparam logic [15:0] SVC_KEY_B = 16'hAAAA;

  typedef enum logic {SVC_IDLE, SVC_ARMED} svc_state_e;
endpackage

// File: rtl/wdog_svc.sv
module wdog_svc
  import wdog_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        wr_i,
  input  logic [15:0] data_i,
  output logic        reload_o
);
  svc_state_e state_q;

  assign reload_o = wr_i && (state_q == SVC_ARMED) && (data_i == SVC_KEY_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= SVC_IDLE;
    else if (clr_i) state_q <= SVC_IDLE;
    else if (wr_i)  state_q <= (data_i == SVC_KEY_A) ? SVC_ARMED : SVC_IDLE;
  end
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int unsigned HALF_TICKS = 16384,
  parameter int unsigned WT_W       = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [WT_W:0]   load_val_i,
  input  logic            run_i,
  input  logic [WT_W-1:0] lead_i,
  output logic            expire_o,
  output logic            pre_o
);
  localparam int unsigned PW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam int unsigned LW = WT_W + 1;

  logic [PW-1:0] presc_q;
  logic [LW-1:0] left_q, left_nxt;
  logic          wrap;

  assign wrap     = run_i && (left_q != '0) && (presc_q == PW'(HALF_TICKS - 1));
  assign left_nxt = left_q - LW'(1);
  assign expire_o = wrap && (left_q == LW'(1));
  assign pre_o    = wrap && (left_nxt == {1'b0, lead_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q <= '0;
      left_q  <= '0;
    end else if (clr_i) begin
      presc_q <= '0;
      left_q  <= '0;
    end else if (load_i) begin
      presc_q <= '0;
      left_q  <= load_val_i;
    end else if (run_i && left_q != '0) begin
      if (wrap) begin
        presc_q <= '0;
        left_q  <= left_nxt;
      end else begin
        presc_q <= presc_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 16384,
  parameter int unsigned AW         = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          dbg_i,
  input  logic          lp_i,
  input  logic          wait_i,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o,
  output logic          irq_o,
  output logic          ext_rst_no,
  output logic          sys_rst_o,
  output logic          pd_wdog_en_o
);
  localparam int unsigned WT_W = 8;

  logic [WT_W-1:0] wt_q, lead_q;
  logic ctrl_en, susp_lp, susp_dbg, susp_wait, ext_to_q, swr_n_q, extr_n_q;
  logic ie_q, flag_q, pde_q;
  logic st_por, st_tout, st_sw;
  logic tout_ext_q, ext_req_q, sys_rst_q;

  logic wr, wr_ctrl, wr_svc, wr_ictl, wr_misc;
  logic reload, en_rise, load, run, expire, pre, sw_trig, to_trig, warm;
  logic [WT_W:0] load_val;

  assign wr      = sel_i && we_i;
  assign wr_ctrl = wr && (addr_i == AW'(OFF_CTRL));
  assign wr_svc  = wr && (addr_i == AW'(OFF_SVC));
  assign wr_ictl = wr && (addr_i == AW'(OFF_ICTL));
  assign wr_misc = wr && (addr_i == AW'(OFF_MISC));

  assign en_rise  = wr_ctrl && wdata_i[CB_EN] && !ctrl_en;
  assign load     = en_rise || reload;
  assign load_val = en_rise ? {1'b0, wdata_i[15:8]} + 9'd1 : {1'b0, wt_q} + 9'd1;
  assign run      = tick_i && ctrl_en && !(susp_dbg && dbg_i)
                    && !(susp_lp && lp_i) && !(susp_wait && wait_i);

  assign sw_trig = tick_i && !swr_n_q;
  assign to_trig = expire && !ext_to_q;
  assign warm    = sw_trig || to_trig;

  wdog_svc u_svc (
    .clk_i, .rst_ni, .clr_i(warm), .wr_i(wr_svc), .data_i(wdata_i), .reload_o(reload)
  );

  wdog_count #(.HALF_TICKS(HALF_TICKS), .WT_W(WT_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(warm), .load_i(load), .load_val_i(load_val),
    .run_i(run), .lead_i(lead_q), .expire_o(expire), .pre_o(pre)
  );

  // control, interrupt control and pin state; status survives warm reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_q <= '0; ctrl_en <= 1'b0; susp_lp <= 1'b0; susp_dbg <= 1'b0;
      susp_wait <= 1'b0; ext_to_q <= 1'b0; swr_n_q <= 1'b1; extr_n_q <= 1'b1;
      ie_q <= 1'b0; flag_q <= 1'b0; lead_q <= '0;
      tout_ext_q <= 1'b0; ext_req_q <= 1'b0; sys_rst_q <= 1'b0;
      st_por <= 1'b1; st_tout <= 1'b0; st_sw <= 1'b0;
    end else if (warm) begin
      wt_q <= '0; ctrl_en <= 1'b0; susp_lp <= 1'b0; susp_dbg <= 1'b0;
      susp_wait <= 1'b0; ext_to_q <= 1'b0; swr_n_q <= 1'b1; extr_n_q <= 1'b1;
      ie_q <= 1'b0; flag_q <= 1'b0; lead_q <= '0;
      tout_ext_q <= 1'b0; ext_req_q <= 1'b0; sys_rst_q <= 1'b1;
      st_por <= 1'b0; st_tout <= !sw_trig; st_sw <= sw_trig;
    end else begin
      sys_rst_q <= 1'b0;
      if (wr_ctrl) begin
        wt_q      <= wdata_i[15:8];
        ctrl_en   <= ctrl_en | wdata_i[CB_EN];
        susp_lp   <= wdata_i[CB_LPS];
        susp_dbg  <= wdata_i[CB_DBGS];
        susp_wait <= wdata_i[CB_WAITS];
        ext_to_q  <= wdata_i[CB_EXTTO];
        swr_n_q   <= wdata_i[CB_SWRN];
        extr_n_q  <= wdata_i[CB_EXTRN];
      end
      if (wr_ictl) begin
        ie_q   <= wdata_i[IB_IE];
        lead_q <= wdata_i[WT_W-1:0];
      end
      if (pre)                            flag_q <= 1'b1;
      else if (wr_ictl && wdata_i[IB_FLAG]) flag_q <= 1'b0;
      if (tick_i)  ext_req_q  <= !extr_n_q;
      if (expire)  tout_ext_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pde_q <= 1'b1;
    else if (wr_misc && !wdata_i[0]) pde_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(OFF_CTRL): rdata_o = {wt_q, susp_wait, 1'b0, extr_n_q, swr_n_q,
                                ext_to_q, ctrl_en, susp_dbg, susp_lp};
      AW'(OFF_ICTL): rdata_o = {ie_q, flag_q, 6'b0, lead_q};
      AW'(OFF_STAT): rdata_o = {11'b0, st_por, 2'b0, st_tout, st_sw};
      AW'(OFF_MISC): rdata_o = {15'b0, pde_q};
      default:       rdata_o = '0;
    endcase
  end

  assign irq_o        = flag_q && ie_q;
  assign ext_rst_no   = !(ext_req_q || tout_ext_q);
  assign sys_rst_o    = sys_rst_q;
  assign pd_wdog_en_o = pde_q;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic sys_rst_o,
  input logic ext_rst_no,
  input logic irq_o,
  input logic pd_wdog_en_o,
  input logic ctrl_en
);
  AST_SYSRST_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(tick_i)); // R2
  AST_SYSRST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o); // R9
  AST_EXT_FALL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ext_rst_no) |-> $past(tick_i)); // R8
  AST_EN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_en) |-> sys_rst_o); // R4
  AST_IRQ_CLR_ON_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> !irq_o); // R6
  AST_PDE_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_wdog_en_o |=> !pd_wdog_en_o); // R10
endmodule

bind wdog_top wdog_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sys_rst_o(sys_rst_o),
  .ext_rst_no(ext_rst_no), .irq_o(irq_o), .pd_wdog_en_o(pd_wdog_en_o),
  .ctrl_en(ctrl_en)
);

// File: tb/wdog_top_tb_top.sv
`timescale 1ns/1ps
module wdog_top_tb_top;
  localparam int unsigned HT = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b0, dbg_i = 1'b0, lp_i = 1'b0, wait_i = 1'b0;
  logic sel_i = 1'b0, we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic irq_o, ext_rst_no, sys_rst_o, pd_wdog_en_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  wdog_top #(.HALF_TICKS(HT), .AW(4)) dut_i (
    .clk_i(clk), .rst_ni, .tick_i, .dbg_i, .lp_i, .wait_i, .sel_i, .we_i,
    .addr_i, .wdata_i, .rdata_o, .irq_o, .ext_rst_no, .sys_rst_o, .pd_wdog_en_o
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk); rst_ni = 1'b0; tick_i = 0; dbg_i = 0; lp_i = 0; wait_i = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); sel_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); sel_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); sel_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o; sel_i = 0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    por();
    rd(4'h0, d); chk("R1 ctrl", d, 16'h0030);
    rd(4'h4, d); chk("R1 stat", d, 16'h0010);
    rd(4'h8, d); chk("R1 misc", d, 16'h0001);
    chk("R1 pins", {13'b0, ext_rst_no, irq_o, sys_rst_o}, 16'h0004);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    por(); wr(4'h0, 16'h0134);
    tick(7); chk("R2 early", {15'b0, sys_rst_o}, 16'h0);
    tick(1); chk("R2 fire", {15'b0, sys_rst_o}, 16'h1);
    @(negedge clk); chk("R2 pulse", {15'b0, sys_rst_o}, 16'h0);
    rd(4'h4, d); chk("R2 stat", d, 16'h0002);
    rd(4'h0, d); chk("R2 ctrl", d, 16'h0030);
  endtask

  task automatic t_service();
    por(); wr(4'h0, 16'h0134); tick(6);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    tick(7); chk("R3 good early", {15'b0, sys_rst_o}, 16'h0);
    tick(1); chk("R3 good fire", {15'b0, sys_rst_o}, 16'h1);
    por(); wr(4'h0, 16'h0134); tick(6);
    wr(4'h2, 16'hAAAA);
    tick(1); chk("R3 lone", {15'b0, sys_rst_o}, 16'h0);
    tick(1); chk("R3 lone fire", {15'b0, sys_rst_o}, 16'h1);
    por(); wr(4'h0, 16'h0134); tick(6);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    tick(1); chk("R3 broken", {15'b0, sys_rst_o}, 16'h0);
    tick(1); chk("R3 broken fire", {15'b0, sys_rst_o}, 16'h1);
  endtask

  task automatic t_sticky();
    logic [15:0] d;
    por(); wr(4'h0, 16'h0134); wr(4'h0, 16'h0130);
    rd(4'h0, d); chk("R4 en kept", d, 16'h0134);
    tick(7); tick(1); chk("R4 still runs", {15'b0, sys_rst_o}, 16'h1);
  endtask

  task automatic t_suspend();
    por(); wr(4'h0, 16'h0136); dbg_i = 1;
    tick(20); chk("R5 held", {15'b0, sys_rst_o}, 16'h0);
    dbg_i = 0;
    tick(7); chk("R5 resume", {15'b0, sys_rst_o}, 16'h0);
    tick(1); chk("R5 fire", {15'b0, sys_rst_o}, 16'h1);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    por(); wr(4'h6, 16'h8001); wr(4'h0, 16'h0234);
    tick(7); chk("R6 early", {15'b0, irq_o}, 16'h0);
    tick(1); chk("R6 fire", {15'b0, irq_o}, 16'h1);
    rd(4'h6, d); chk("R6 flag", d, 16'hC001);
    wr(4'h6, 16'hC001); chk("R6 w1c", {15'b0, irq_o}, 16'h0);
    rd(4'h6, d); chk("R6 cleared", d, 16'h8001);
    tick(4); chk("R6 expiry", {15'b0, sys_rst_o}, 16'h1);
  endtask

  task automatic t_ext_tout();
    logic [15:0] d;
    por(); wr(4'h0, 16'h013C);
    tick(7); chk("R7 early", {15'b0, ext_rst_no}, 16'h1);
    tick(1); chk("R7 pin", {14'b0, ext_rst_no, sys_rst_o}, 16'h0);
    rd(4'h4, d); chk("R7 stat", d, 16'h0010);
    tick(10); chk("R7 held", {14'b0, ext_rst_no, sys_rst_o}, 16'h0);
  endtask

  task automatic t_ext_sw();
    por(); wr(4'h0, 16'h0010);
    repeat (3) @(negedge clk);
    chk("R8 before tick", {15'b0, ext_rst_no}, 16'h1);
    tick(1); chk("R8 asserted", {15'b0, ext_rst_no}, 16'h0);
    wr(4'h0, 16'h0030); chk("R8 hold", {15'b0, ext_rst_no}, 16'h0);
    tick(1); chk("R8 release", {15'b0, ext_rst_no}, 16'h1);
  endtask

  task automatic t_swrst();
    logic [15:0] d;
    por(); wr(4'h0, 16'h0020);
    repeat (3) @(negedge clk);
    chk("R9 before tick", {15'b0, sys_rst_o}, 16'h0);
    tick(1); chk("R9 fire", {15'b0, sys_rst_o}, 16'h1);
    rd(4'h4, d); chk("R9 stat", d, 16'h0001);
    rd(4'h0, d); chk("R9 ctrl", d, 16'h0030);
  endtask

  task automatic t_misc();
    logic [15:0] d;
    por(); wr(4'h8, 16'h0000);
    chk("R10 cleared", {15'b0, pd_wdog_en_o}, 16'h0);
    wr(4'h8, 16'h0001);
    chk("R10 no set", {15'b0, pd_wdog_en_o}, 16'h0);
    rd(4'h8, d); chk("R10 read", d, 16'h0000);
  endtask

  task automatic t_wt_change();
    por(); wr(4'h0, 16'h0134); wr(4'h0, 16'h0334);
    tick(7); chk("R11 old early", {15'b0, sys_rst_o}, 16'h0);
    tick(1); chk("R11 old fire", {15'b0, sys_rst_o}, 16'h1);
    wr(4'h0, 16'h0134); tick(2); wr(4'h0, 16'h0334);
    wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
    tick(15); chk("R11 new early", {15'b0, sys_rst_o}, 16'h0);
    tick(1); chk("R11 new fire", {15'b0, sys_rst_o}, 16'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_timeout();
    t_service();
    t_sticky();
    t_suspend();
    t_irq();
    t_ext_tout();
    t_ext_sw();
    t_swrst();
    t_misc();
    t_wt_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule